// File: doc/BRIEF.md
# Sleep-Line Deassertion Glitch Filter

This block conditions an active-low sleep request line before a power sequencer sees it. It treats the two edges differently. A falling edge means the low-power request is asserted, and the block reports it at once. A rising edge means the request is released, and the block reports it only if the line is still high after a hold window measured in millisecond ticks. A short invalid high pulse therefore never reaches the sequencer.

The raw line first passes through a two-stage synchroniser. The filtered level is not a delayed copy of the line. It is the synchronised level gated by an internal "accepted" flag. The flag is cleared by a reported assertion and set again only by a confirmed release.

Each reported change also raises a one-cycle event strobe, which the sequencer uses to re-evaluate its state. The FSM has two states. `ST_IDLE` means no release check is pending. `ST_HOLD` means a release check is waiting for the hold window to end. There are three transitions:
- IDLE→HOLD on a synchronised rising edge.
- HOLD→HOLD (restart) on a further rising edge.
- HOLD→IDLE on timer expiry.

Top module: `sleepline_filter`

## Requirements
- R1: After reset the accepted flag is set, no check is pending and `line_evt` is 0. With `line_raw` held high, `line_filt` reads 1.
- R2: `line_raw` reaches the filter through SYNC_STAGES (default 2) flops. With the accepted flag set, a change on `line_raw` driven between edges shows on `line_filt` after the second rising clock edge and not after the first.
- R3: A falling edge detected in ST_IDLE clears the accepted flag and pulses `line_evt` high for exactly one cycle. The pulse appears after the third clock edge following the change on `line_raw`.
- R4: A rising edge moves the FSM to ST_HOLD. It produces no event, and `line_filt` stays 0 while the check is pending.
- R5: In ST_HOLD the HOLD_TICKS-th `tick_1ms` pulse (default 3) ends the check. If the synchronised line is then high, the accepted flag is set, `line_evt` pulses once and `line_filt` becomes 1.
- R6: A falling edge during ST_HOLD produces no event. When the window then ends with the line low, no event is produced, the flag stays clear and `line_filt` stays 0.
- R7: A new rising edge during ST_HOLD restarts the tick count. Acceptance then needs HOLD_TICKS further ticks.
- R8: `line_filt` equals the synchronised line ANDed with the accepted flag. After an accepted release, a falling line drops `line_filt` within two clock edges.
- R9: `tick_1ms` pulses in ST_IDLE produce no event and do not change `line_filt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| line_raw | input | 1 | Asynchronous active-low sleep line |
| line_filt | output | 1 | Filtered line level |
| line_evt | output | 1 | One-cycle change strobe to the sequencer |

## Verification
Suppose the FSM stays in ST_HOLD when it should not, or leaves it too early. Then the acceptance event appears on the wrong tick or never appears, and `line_filt` shows the mistake on the same cycle. A stale accepted flag shows as `line_filt` rising at once on a release, or staying high after a glitch. That is visible within three clock edges of the rising edge. A wrong synchroniser depth shifts the fall on `line_filt` by a cycle, and the event count around each pulse exposes a missing or extra strobe before the next stimulus.

// File: rtl/slf_pkg.sv
package slf_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } slf_state_e;
endpackage

// File: rtl/slf_sync.sv
module slf_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RESET_LVL;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= RESET_LVL;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RESET_LVL;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign q_sync = chain_q[STAGES-1];
    assign rise   = chain_q[STAGES-1] & ~prev_q;
    assign fall   = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/slf_hold_timer.sv
module slf_hold_timer #(
    parameter int TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign expire = run & tick & ~restart & (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (restart || !run) cnt_q <= '0;
        else if (tick)          cnt_q <= expire ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/sleepline_filter.sv
module sleepline_filter
    import slf_pkg::*;
#(
    parameter int HOLD_TICKS  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1ms,
    input  logic line_raw,
    output logic line_filt,
    output logic line_evt
);
    slf_state_e state_q, state_d;
    logic sync_lvl, rise, fall, expire;
    logic ok_q, evt_q;

    slf_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_LVL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (line_raw),
        .q_sync  (sync_lvl),
        .rise    (rise),
        .fall    (fall)
    );

    slf_hold_timer #(
        .TICKS (HOLD_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (rise),
        .run     (state_q == ST_HOLD),
        .tick    (tick_1ms),
        .expire  (expire)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rise) state_d = ST_HOLD;
            ST_HOLD: begin
                if (rise)        state_d = ST_HOLD;
                else if (expire) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q  <= 1'b1;
            evt_q <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (fall) begin
                        ok_q  <= 1'b0;
                        evt_q <= 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (!rise && expire && sync_lvl) begin
                        ok_q  <= 1'b1;
                        evt_q <= 1'b1;
                    end
                end
                default: evt_q <= 1'b0;
            endcase
        end
    end

    assign line_filt = sync_lvl & ok_q;
    assign line_evt  = evt_q;
endmodule

// File: rtl/slf_chk.sv
module slf_chk
    import slf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1ms,
    input logic       line_evt,
    input slf_state_e state_q,
    input logic       ok_q,
    input logic       rise,
    input logic       fall
);
    AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_evt |=> !line_evt); // R3

    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && fall) |=> (line_evt && !ok_q)); // R3

    AST_RISE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (state_q == ST_HOLD && !line_evt)); // R4

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !tick_1ms) |=> (!line_evt && $stable(ok_q))); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !fall) |=> !line_evt); // R9
endmodule

bind sleepline_filter slf_chk u_slf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1ms (tick_1ms),
    .line_evt (line_evt),
    .state_q  (state_q),
    .ok_q     (ok_q),
    .rise     (rise),
    .fall     (fall)
);

// File: tb/sleepline_filter_bench.sv
module sleepline_filter_bench;
    localparam int HOLD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1ms = 1'b0;
    logic line_raw = 1'b1;
    logic line_filt, line_evt;

    int n_cmp = 0;
    int n_bad = 0;
    int ev_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sleepline_filter #(.HOLD_TICKS(HOLD), .SYNC_STAGES(2)) u_sleepline_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1ms  (tick_1ms),
        .line_raw  (line_raw),
        .line_filt (line_filt),
        .line_evt  (line_evt)
    );

    always @(negedge clk) if (rst_n && line_evt) ev_cnt++;

    task automatic chk(input int act, input int exp, input string req);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_once();
        tick_1ms = 1'b1;
        @(negedge clk);
        tick_1ms = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int ev0;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk(line_filt, 1, "R1 filt after reset");
        chk(line_evt, 0, "R1 evt after reset");
        chk(ev_cnt, 0, "R1 no event after reset");

        // R2/R3: first assertion edge
        line_raw = 1'b0;
        cyc(1);
        chk(line_filt, 1, "R2 filt after one edge");
        chk(line_evt, 0, "R3 evt not yet");
        cyc(1);
        chk(line_filt, 0, "R2 filt after two edges");
        chk(line_evt, 0, "R3 evt not yet");
        cyc(1);
        chk(line_evt, 1, "R3 evt on third edge");
        cyc(1);
        chk(line_evt, 0, "R3 evt one cycle");
        chk(ev_cnt, 1, "R3 single event");

        // R9: ticks in idle
        ev0 = ev_cnt;
        for (int k = 0; k < 4; k++) tick_once();
        chk(ev_cnt - ev0, 0, "R9 idle ticks no event");
        chk(line_filt, 0, "R9 idle ticks filt");

        // sweep of high-pulse widths in ticks
        for (int n = 0; n <= 5; n++) begin
            int acc;
            acc = (n >= HOLD) ? 1 : 0;
            ev0 = ev_cnt;
            line_raw = 1'b1;
            cyc(4);
            chk(ev_cnt - ev0, 0, "R4 no event on rise");
            chk(line_filt, 0, "R4 filt low while pending");
            for (int k = 0; k < n; k++) begin
                tick_once();
                if (k + 1 < HOLD) chk(line_filt, 0, "R4 filt low before window end");
            end
            chk(ev_cnt - ev0, acc, acc ? "R5 accepted release" : "R4 pending no event");
            chk(line_filt, acc, acc ? "R5 filt high" : "R4 filt low");
            line_raw = 1'b0;
            cyc(2);
            chk(line_filt, 0, "R8 filt drops within two edges");
            cyc(2);
            chk(ev_cnt - ev0, 2 * acc, acc ? "R3 fall event after accept" : "R6 fall in hold silent");
            for (int k = 0; k < HOLD; k++) tick_once();
            chk(ev_cnt - ev0, 2 * acc, "R6 expiry with line low silent");
            chk(line_filt, 0, "R6 filt stays low");
        end

        // R7: restart on a new rise during hold
        ev0 = ev_cnt;
        line_raw = 1'b1;
        cyc(4);
        tick_once();
        tick_once();
        line_raw = 1'b0;
        cyc(4);
        line_raw = 1'b1;
        cyc(4);
        tick_once();
        tick_once();
        chk(ev_cnt - ev0, 0, "R7 restarted count not yet done");
        chk(line_filt, 0, "R7 filt low before restart window");
        tick_once();
        chk(ev_cnt - ev0, 1, "R7 accepted after full window");
        chk(line_filt, 1, "R7 filt high");
        line_raw = 1'b0;
        cyc(4);
        chk(ev_cnt - ev0, 2, "R8 fall reported after restart accept");
        chk(line_filt, 0, "R8 filt low");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule